// File: doc/BRIEF.md
# Paged Configuration Register File with Soft Resets

This block is a byte-wide configuration register file that sits behind a plain address/data strobe port. A serial target front end (an SMBus or I2C target, for example) would normally drive that port. The register space is split into one shared control bank and four channel banks of identical layout. A page register that answers at address 0xFF decides which bank every other access reaches. In normal use, firmware first writes the page register and then reads or writes the registers of the bank it selected.

Each bank type has its own self-clearing soft reset. The shared bank restores itself to its default values when bit 6 of its register 0x04 is written with a 1. A channel bank restores itself when bit 2 of its register 0x00 is written with a 1 while that channel is selected. Neither reset reaches the registers of the other bank type, the other channels or the page register. An active-low hardware reset loads defaults into every bank and clears the page register.

Top module: `paged_regfile`

## Requirements
- R1: While `rst_n` is low, every shared register and every channel register takes its parameter default, and the page register becomes 0x00.
- R2: Address 0xFF reaches the page register whatever bank is selected. Only its bits 2:0 are stored and the other bits read as 0. Neither soft reset changes it.
- R3: While page bit 2 is 0, reads and writes to addresses 0x00 to 0x3F reach the shared bank.
- R4: While page bit 2 is 1, reads and writes to addresses 0x00 to 0x3F reach the channel bank numbered by page bits 1:0. The other channel banks do not change.
- R5: Writing shared address 0x04 with bit 6 set stores the other bits of the byte. On the next rising edge, every shared register returns to its default.
- R6: A soft reset bit reads 1 only in the single cycle between its write and the reset, and reads 0 from then on.
- R7: A shared soft reset leaves every channel register unchanged.
- R8: Writing channel address 0x00 with bit 2 set returns only the selected channel bank to its defaults on the next edge. The other channels and the shared bank keep their contents.
- R9: A write that reaches a bank during that bank's pending-reset cycle is dropped, because the reset wins. A write to the page register in that same cycle still takes effect.
- R10: Addresses 0x40 to 0xFE read as 0x00, and writes to them change nothing.
- R11: Read data follows the current address and page combinationally. A write takes effect at the rising edge where `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address and page |

## Verification
The hardest situation to create is a write that lands in the one cycle between a soft reset write and the reset itself. That window is a single clock wide and is visible only through the reset bit reading 1. To reach it, the stimulus issues the reset write and, on the very next clock, either a data write into the same bank or a write to the page register. A read on the clock after that shows whether the bank write was dropped and whether the page register write was kept. The bench also fills every channel with its own pattern before each soft reset. This makes any leak of a reset into a neighbouring bank show up as a changed byte.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int REG_CNT      = 64;
  localparam int BYTE_W       = 8;
  localparam logic [7:0] PAGE_ADDR = 8'hFF;
  localparam int PAGE_BANK_BIT = 2;
  localparam int SHR_RST_ADDR = 4;
  localparam int SHR_RST_BIT  = 6;
  localparam int CH_RST_ADDR  = 0;
  localparam int CH_RST_BIT   = 2;

  // Power-on contents of the shared bank: index shifted up, xor pattern.
  function automatic logic [REG_CNT*BYTE_W-1:0] shared_defaults();
    logic [REG_CNT*BYTE_W-1:0] v;
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      b = {i[5:0], 2'b01} ^ 8'hA0;
      if (i == SHR_RST_ADDR) b[SHR_RST_BIT] = 1'b0;
      v[i*BYTE_W +: BYTE_W] = b;
    end
    return v;
  endfunction

  // Power-on contents of each channel bank: linear ramp.
  function automatic logic [REG_CNT*BYTE_W-1:0] chan_defaults();
    logic [REG_CNT*BYTE_W-1:0] v;
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      b = 8'(i * 7 + 19);
      if (i == CH_RST_ADDR) b[CH_RST_BIT] = 1'b0;
      v[i*BYTE_W +: BYTE_W] = b;
    end
    return v;
  endfunction
endpackage

// File: rtl/page_select_reg.sv
module page_select_reg #(
  parameter int DW   = 8,
  parameter int CH_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          chan_en,
  output logic [CH_W-1:0] chan_sel,
  output logic [DW-1:0] rdata
);
  localparam int BANK_BIT = regbank_pkg::PAGE_BANK_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en  <= 1'b0;
      chan_sel <= '0;
    end else if (wr_en) begin
      chan_en  <= wdata[BANK_BIT];
      chan_sel <= wdata[CH_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[BANK_BIT] = chan_en;
    rdata[CH_W-1:0] = chan_sel;
  end
endmodule

// File: rtl/page_addr_decode.sv
module page_addr_decode #(
  parameter int AW     = 8,
  parameter int NREGS  = 64,
  parameter int NUM_CH = 4,
  localparam int OFS_W = $clog2(NREGS),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [AW-1:0]    addr,
  input  logic             chan_en,
  input  logic [CH_W-1:0]  chan_sel,
  output logic             hit_page,
  output logic             hit_shared,
  output logic [NUM_CH-1:0] hit_chan,
  output logic [OFS_W-1:0] offset
);
  logic in_bank;

  assign hit_page   = (addr == regbank_pkg::PAGE_ADDR);
  assign in_bank    = (int'(addr) < NREGS);
  assign hit_shared = in_bank && !chan_en;
  assign offset     = addr[OFS_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign hit_chan[g] = in_bank && chan_en && (chan_sel == CH_W'(g));
  end
endmodule

// File: rtl/soft_reg_bank.sv
module soft_reg_bank #(
  parameter int NREGS    = 64,
  parameter int DW       = 8,
  parameter int RST_ADDR = 0,
  parameter int RST_BIT  = 0,
  parameter logic [NREGS*DW-1:0] DEFAULTS = '0,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rst_pend
);
  localparam logic [DW-1:0] RST_MASK = DW'(1) << RST_BIT;
  localparam logic [AW-1:0] RST_IDX  = AW'(RST_ADDR);

  logic [DW-1:0] mem [NREGS];
  logic          hit_rst;

  assign hit_rst = (addr == RST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= DEFAULTS[i*DW +: DW];
      rst_pend <= 1'b0;
    end else if (rst_pend) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= DEFAULTS[i*DW +: DW];
      rst_pend <= 1'b0;
    end else if (wr_en) begin
      mem[addr] <= hit_rst ? (wdata & ~RST_MASK) : wdata;
      rst_pend  <= hit_rst && wdata[RST_BIT];
    end
  end

  always_comb begin
    rdata = mem[addr];
    if (hit_rst) rdata = (mem[addr] & ~RST_MASK) | (rst_pend ? RST_MASK : '0);
  end
endmodule

// File: rtl/paged_regfile.sv
module paged_regfile #(
  parameter int NUM_CH = 4,
  parameter int NREGS  = regbank_pkg::REG_CNT,
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter logic [NREGS*DW-1:0] SHR_DEFAULTS = regbank_pkg::shared_defaults(),
  parameter logic [NREGS*DW-1:0] CH_DEFAULTS  = regbank_pkg::chan_defaults()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int OFS_W = $clog2(NREGS);

  logic              page_chan_en;
  logic [CH_W-1:0]   page_chan;
  logic [DW-1:0]     page_rdata;
  logic [2:0]        page_q;
  logic              hit_page, hit_shared;
  logic [NUM_CH-1:0] hit_chan;
  logic [OFS_W-1:0]  offset;
  logic [DW-1:0]     shr_rdata;
  logic [DW-1:0]     ch_rdata [NUM_CH];
  logic              shr_soft_rst;
  logic [NUM_CH-1:0] ch_soft_rst;

  page_select_reg #(.DW(DW), .CH_W(CH_W)) u_page (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_page), .wdata(reg_wdata),
    .chan_en(page_chan_en), .chan_sel(page_chan), .rdata(page_rdata)
  );

  assign page_q = page_rdata[2:0];

  page_addr_decode #(.AW(AW), .NREGS(NREGS), .NUM_CH(NUM_CH)) u_dec (
    .addr(reg_addr), .chan_en(page_chan_en), .chan_sel(page_chan),
    .hit_page(hit_page), .hit_shared(hit_shared), .hit_chan(hit_chan), .offset(offset)
  );

  soft_reg_bank #(
    .NREGS(NREGS), .DW(DW), .RST_ADDR(regbank_pkg::SHR_RST_ADDR),
    .RST_BIT(regbank_pkg::SHR_RST_BIT), .DEFAULTS(SHR_DEFAULTS)
  ) u_shared (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_shared), .addr(offset),
    .wdata(reg_wdata), .rdata(shr_rdata), .rst_pend(shr_soft_rst)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    soft_reg_bank #(
      .NREGS(NREGS), .DW(DW), .RST_ADDR(regbank_pkg::CH_RST_ADDR),
      .RST_BIT(regbank_pkg::CH_RST_BIT), .DEFAULTS(CH_DEFAULTS)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit_chan[g]), .addr(offset),
      .wdata(reg_wdata), .rdata(ch_rdata[g]), .rst_pend(ch_soft_rst[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_page)        reg_rdata = page_rdata;
    else if (hit_shared) reg_rdata = shr_rdata;
    else begin
      for (int i = 0; i < NUM_CH; i++)
        if (hit_chan[i]) reg_rdata = ch_rdata[i];
    end
  end
endmodule

// File: rtl/paged_regfile_chk.sv
module paged_regfile_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [2:0]        page_q,
  input logic              shr_pend,
  input logic [NUM_CH-1:0] ch_pend
);
  // R5: a shared reset write arms the shared reset
  a_r5_shr_rst_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h04 && reg_wdata[6] && !page_q[2] && !shr_pend) |=> shr_pend);

  // R6: the shared reset lasts one cycle
  a_r6_shr_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    shr_pend |=> !shr_pend);

  // R6: a channel reset never stays pending for two cycles in the same bank
  a_r6_ch_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_pend) |=> ((ch_pend & $past(ch_pend)) == '0));

  // R8: a channel reset write arms exactly the selected channel
  a_r8_ch_rst_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h00 && reg_wdata[2] && page_q[2] && ch_pend == '0)
      |=> ch_pend[$past(page_q[1:0])]);

  // R8: at most one channel reset at a time
  a_r8_ch_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_pend));

  // R2: soft resets leave the page register alone
  a_r2_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((shr_pend || (|ch_pend)) && !(reg_wr && reg_addr == 8'hFF)) |=> $stable(page_q));

  // R10: unimplemented addresses read as zero
  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= 8'h40 && reg_addr != 8'hFF) |-> (reg_rdata == 8'h00));
endmodule

bind paged_regfile paged_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_q(page_q),
  .shr_pend(shr_soft_rst), .ch_pend(ch_soft_rst)
);

// File: tb/paged_regfile_tb_top.sv
module paged_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  paged_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Behavioural reference model
  logic [7:0] sh_m [64];
  logic [7:0] ch_m [4][64];
  logic [7:0] page_m;
  bit         sh_pend;
  int         ch_pend;

  function automatic logic [7:0] sh_def(int i);
    logic [7:0] v = 8'((i * 4 + 1) ^ 160);
    if (i == 4) v = v & 8'hBF;
    return v;
  endfunction

  function automatic logic [7:0] ch_def(int i);
    logic [7:0] v = 8'((i * 7 + 19) % 256);
    if (i == 0) v = v & 8'hFB;
    return v;
  endfunction

  task automatic model_hw_reset();
    for (int i = 0; i < 64; i++) begin
      sh_m[i] = sh_def(i);
      for (int c = 0; c < 4; c++) ch_m[c][i] = ch_def(i);
    end
    page_m = 8'h00; sh_pend = 0; ch_pend = -1;
  endtask

  function automatic logic [7:0] model_read(int a);
    logic [7:0] v;
    int c;
    if (a == 255) return page_m;
    if (a >= 64) return 8'h00;
    if (!page_m[2]) begin
      v = sh_m[a];
      if (a == 4 && sh_pend) v = v | 8'h40;
    end else begin
      c = int'(page_m[1:0]);
      v = ch_m[c][a];
      if (a == 0 && ch_pend == c) v = v | 8'h04;
    end
    return v;
  endfunction

  task automatic model_edge(int a, bit wr, logic [7:0] wd);
    bit osh = sh_pend;
    int och = ch_pend;
    int c;
    sh_pend = 0; ch_pend = -1;
    if (osh) for (int i = 0; i < 64; i++) sh_m[i] = sh_def(i);
    if (och >= 0) for (int i = 0; i < 64; i++) ch_m[och][i] = ch_def(i);
    if (wr) begin
      if (a == 255) page_m = wd & 8'h07;
      else if (a < 64) begin
        if (!page_m[2]) begin
          if (!osh) begin
            if (a == 4) begin sh_m[4] = wd & 8'hBF; if (wd[6]) sh_pend = 1; end
            else sh_m[a] = wd;
          end
        end else begin
          c = int'(page_m[1:0]);
          if (och != c) begin
            if (a == 0) begin ch_m[c][0] = wd & 8'hFB; if (wd[2]) ch_pend = c; end
            else ch_m[c][a] = wd;
          end
        end
      end
    end
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: addr=%02h actual=%02h expected=%02h", tag, reg_addr, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, compare read data, model the rising edge
  task automatic cyc(int a, bit wr, logic [7:0] wd, string tag);
    @(negedge clk);
    reg_addr = 8'(a); reg_wr = wr; reg_wdata = wd;
    #1;
    check(tag, reg_rdata, model_read(a));
    @(posedge clk);
    model_edge(a, wr, wd);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 64; a++) cyc(a, 0, 8'h00, tag);
    cyc(255, 0, 8'h00, tag);
  endtask

  task automatic sel(logic [7:0] p, string tag);
    cyc(255, 1, p, tag);
  endtask

  task automatic fill(int seed, string tag);
    for (int a = 1; a < 64; a++) cyc(a, 1, 8'((a * 13 + seed) % 256), tag);
  endtask

  task automatic do_hw_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    model_hw_reset();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    model_hw_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: defaults in every bank after hardware reset
    sweep("R1 shared defaults");
    for (int c = 0; c < 4; c++) begin
      sel(8'(4 + c), "R4 select");
      sweep("R1 channel defaults");
    end

    // R3, R4, R11: distinct patterns per bank, isolation
    sel(8'h00, "R3 select shared");
    fill(5, "R3 shared write");
    for (int c = 0; c < 4; c++) begin
      sel(8'(4 + c), "R4 select");
      fill(40 * c + 1, "R4 channel write");
    end
    sel(8'h00, "R3 select shared");
    sweep("R3 shared readback");
    for (int c = 0; c < 4; c++) begin
      sel(8'(4 + c), "R4 select");
      sweep("R4 channel readback");
    end

    // R10: writes to unimplemented addresses ignored
    cyc(64, 1, 8'hAA, "R10 write");
    cyc(150, 1, 8'h55, "R10 write");
    cyc(254, 1, 8'hFF, "R10 write");
    cyc(64, 0, 8'h00, "R10 read");
    cyc(254, 0, 8'h00, "R10 read");
    sweep("R10 channel 3 intact");

    // R2: page register stores only bits 2:0
    sel(8'hF9, "R2 page write");
    cyc(255, 0, 8'h00, "R2 page readback");

    // R5, R6, R7: shared soft reset, channels unchanged
    sel(8'h00, "R3 select shared");
    cyc(4, 1, 8'h55, "R5 reset write");
    cyc(4, 0, 8'h00, "R6 bit pending");
    cyc(4, 0, 8'h00, "R6 bit cleared");
    sweep("R5 shared defaults");
    for (int c = 0; c < 4; c++) begin
      sel(8'(4 + c), "R4 select");
      sweep("R7 channels unchanged");
    end

    // R9: bank write in the pending cycle is dropped
    sel(8'h00, "R3 select shared");
    fill(77, "R3 shared write");
    cyc(4, 1, 8'h40, "R5 reset write");
    cyc(10, 1, 8'hEE, "R9 write in pending cycle");
    cyc(10, 0, 8'h00, "R9 write dropped");
    // R9: page write in the pending cycle still lands
    cyc(4, 1, 8'h40, "R5 reset write");
    sel(8'h06, "R9 page write in pending cycle");
    cyc(255, 0, 8'h00, "R9 page kept");
    cyc(0, 0, 8'h00, "R8 channel 2 still filled");

    // R8: channel 2 reset, others intact
    cyc(0, 1, 8'hFF, "R8 reset write");
    cyc(0, 0, 8'h00, "R6 channel bit pending");
    cyc(0, 0, 8'h00, "R6 channel bit cleared");
    sweep("R8 channel 2 defaults");
    sel(8'h05, "R4 select");
    sweep("R8 channel 1 intact");
    sel(8'h00, "R3 select shared");
    fill(9, "R3 shared write");
    sel(8'h07, "R4 select");
    cyc(0, 1, 8'h04, "R8 reset write");
    cyc(5, 1, 8'h12, "R9 channel write dropped");
    sweep("R8 channel 3 defaults");
    sel(8'h00, "R3 select shared");
    sweep("R8 shared intact");

    // R1: hardware reset mid-run
    sel(8'h05, "R4 select");
    do_hw_reset();
    cyc(255, 0, 8'h00, "R1 page cleared");
    sweep("R1 shared after hw reset");
    sel(8'h05, "R4 select");
    sweep("R1 channel after hw reset");

    done = 1'b1;
    finish_run();
  end
endmodule